// File: doc/BRIEF.md
# Fracturable Eight-Input Lookup Cell

This block is a configurable logic cell with eight logic input pins and two result outputs. Its 128-bit truth-table memory is treated as two 64-bit halves. A 3-bit mode code picks how those halves are wired to the eight pins. The cell can act as one six-input function. It can act as two smaller functions with separate inputs. It can act as two functions that share some of their pins. It can also act as two six-input functions that read the same half through four common pins, which is enough to build a 4x2 crossbar in one cell.

The truth table is written through a one-bit serial configuration port, with one bit shifted per clock. Each output has its own flip-flop, and a per-output select bit chooses between the registered value and the combinational result. A smaller function always uses the low-order entries of its half. Its index is formed from its own pins, with the lowest-numbered pin as the least significant index bit.

Top module: `lut8_frac_cell`

## Requirements
- R1: Mode 0 (quad pair): result A = T_A[in[3:0]] and result B = T_B[in[7:4]]. T_A is configuration bits 63..0 and T_B is bits 127..64.
- R2: Mode 1 (five/three): result A = T_A[in[4:0]] and result B = T_B[in[7:5]].
- R3: Mode 2 (five/four, in[4] shared): result A = T_A[in[4:0]] and result B = T_B[in[7:4]].
- R4: Mode 3 (five/five, in[4:3] shared): result A = T_A[in[4:0]] and result B = T_B[in[7:3]].
- R5: Mode 4 (single six-input function): result A = T_A[in[5:0]] and result B = 0.
- R6: Mode 5 (twin six-input functions on one table): result A = T_A[{in[5:4],in[3:0]}] and result B = T_A[{in[7:6],in[3:0]}]. T_B is not used.
- R7: Mode codes 6 and 7 make both results 0.
- R8: With cfg_en high, each rising edge shifts cfg_din into configuration bit 0 and moves every bit up by one. After 128 shifts, the first bit sent sits in bit 127 (the top of T_B) and the last sent sits in bit 0 (T_A[0]).
- R9: y[0] carries result A and y[1] carries result B. When reg_sel[k] is 1, y[k] shows the output register. When it is 0, y[k] shows the combinational result.
- R10: On a rising edge with ce high and cfg_en low, each output register loads its result. With ce low, the register keeps its value.
- R11: While cfg_en is high, both output registers keep their value whatever ce is.
- R12: A synchronous active-high rst clears both output registers and the whole truth table to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Fracture mode code |
| lut_in | input | 8 | Logic input pins |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Configuration serial data |
| ce | input | 1 | Shared clock enable for output registers |
| reg_sel | input | 2 | Per-output registered/combinational select |
| y | output | 2 | Cell outputs, bit 0 = A, bit 1 = B |

## Verification
The bench sweeps pseudo-random pin patterns through every mode, including the two unused codes. Wrong pin routing or a missing shared pin would show up as a mismatch on result B, and an unused code that leaked table data would give nonzero outputs. It loads known tables and probes T_A[0], T_A[63] and T_B[31], so a reversed or off-by-one shift order would place those bits wrongly. It reloads the table while the registered outputs are selected and the clock enable is high, so registers that followed the changing table would move. It also loads a crossbar table in the twin mode, so a design that read the second half there would route the wrong data.

// File: rtl/lut8_pkg.sv
`timescale 1ns/1ps
package lut8_pkg;

    localparam int N_IN    = 8;
    localparam int N_OUT   = 2;
    localparam int IDX_W   = 6;
    localparam int HALF    = 1 << IDX_W;
    localparam int CFG_W   = 2 * HALF;
    localparam int MODE_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        M_QUAD_PAIR  = 3'd0,
        M_FIVE_THREE = 3'd1,
        M_FIVE_FOUR  = 3'd2,
        M_FIVE_FIVE  = 3'd3,
        M_SIX        = 3'd4,
        M_SIX_TWIN   = 3'd5
    } lut8_mode_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx_a;
        logic [IDX_W-1:0] idx_b;
        logic             en_a;
        logic             en_b;
        logic             b_reads_a;
    } lut8_route_t;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] m);
        return m <= 3'd5;
    endfunction

endpackage

// File: rtl/lut8_cfg_chain.sv
`timescale 1ns/1ps
module lut8_cfg_chain
    import lut8_pkg::*;
#(
    parameter int BITS = CFG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            shift_din,
    output logic [BITS-1:0] table_q
);

    always_ff @(posedge clk) begin
        if (rst)
            table_q <= '0;
        else if (shift_en)
            table_q <= {table_q[BITS-2:0], shift_din};
    end

    // R8: the table only moves while shifting
    a_r8_table_frozen: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(table_q));

    // R12: reset empties the table
    a_r12_table_clear: assert property (@(posedge clk)
        rst |=> table_q == '0);

endmodule

// File: rtl/lut8_route.sv
`timescale 1ns/1ps
module lut8_route
    import lut8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [N_IN-1:0]   pins,
    output lut8_route_t       route
);

    always_comb begin
        route = '0;
        case (lut8_mode_e'(mode))
            M_QUAD_PAIR: begin
                route.idx_a = {2'b00, pins[3:0]};
                route.idx_b = {2'b00, pins[7:4]};
                route.en_a  = 1'b1;
                route.en_b  = 1'b1;
            end
            M_FIVE_THREE: begin
                route.idx_a = {1'b0, pins[4:0]};
                route.idx_b = {3'b000, pins[7:5]};
                route.en_a  = 1'b1;
                route.en_b  = 1'b1;
            end
            M_FIVE_FOUR: begin
                route.idx_a = {1'b0, pins[4:0]};
                route.idx_b = {2'b00, pins[7:4]};
                route.en_a  = 1'b1;
                route.en_b  = 1'b1;
            end
            M_FIVE_FIVE: begin
                route.idx_a = {1'b0, pins[4:0]};
                route.idx_b = {1'b0, pins[7:3]};
                route.en_a  = 1'b1;
                route.en_b  = 1'b1;
            end
            M_SIX: begin
                route.idx_a = pins[5:0];
                route.en_a  = 1'b1;
            end
            M_SIX_TWIN: begin
                route.idx_a     = pins[5:0];
                route.idx_b     = {pins[7:6], pins[3:0]};
                route.en_a      = 1'b1;
                route.en_b      = 1'b1;
                route.b_reads_a = 1'b1;
            end
            default: route = '0;
        endcase
    end

    // R3: in the five/four mode both halves see the one shared pin
    a_r3_shared_pin: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd2) |-> (route.idx_a[4] == route.idx_b[0]));

    // R4: in the five/five mode both halves see the two shared pins
    a_r4_shared_pair: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd3) |-> (route.idx_a[4:3] == route.idx_b[1:0]));

    // R5: single wide function leaves the second half idle
    a_r5_b_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd4) |-> !route.en_b);

endmodule

// File: rtl/lut8_eval.sv
`timescale 1ns/1ps
module lut8_eval
    import lut8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  lut8_route_t       route,
    input  logic [CFG_W-1:0]  table_q,
    output logic [N_OUT-1:0]  res
);

    logic [HALF-1:0] half_a;
    logic [HALF-1:0] half_b;
    logic [HALF-1:0] src_b;

    assign half_a = table_q[HALF-1:0];
    assign half_b = table_q[CFG_W-1:HALF];

    always_comb begin
        src_b  = route.b_reads_a ? half_a : half_b;
        res[0] = route.en_a & half_a[route.idx_a];
        res[1] = route.en_b & src_b[route.idx_b];
    end

    // R7: reserved codes produce nothing
    a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
        !mode_is_legal(mode) |-> (res == '0));

    // R6: twin functions with equal selects give equal results
    a_r6_twin_match: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd5 && route.idx_a == route.idx_b) |-> (res[0] == res[1]));

endmodule

// File: rtl/lut8_out_bit.sv
`timescale 1ns/1ps
module lut8_out_bit (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    input  logic hold,
    input  logic use_reg,
    input  logic d,
    output logic y
);

    logic q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (ce && !hold)
            q <= d;
    end

    assign y = use_reg ? q : d;

    // R11: configuration freezes the register
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));

    // R10: no enable, no change
    a_r10_ce_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q));

    // R12: reset clears the register
    a_r12_reg_clear: assert property (@(posedge clk)
        rst |=> !q);

endmodule

// File: rtl/lut8_frac_cell.sv
`timescale 1ns/1ps
module lut8_frac_cell
    import lut8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode,
    input  logic [N_IN-1:0]   lut_in,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic              ce,
    input  logic [N_OUT-1:0]  reg_sel,
    output logic [N_OUT-1:0]  y
);

    logic [CFG_W-1:0] table_q;
    lut8_route_t      route;
    logic [N_OUT-1:0] res;

    lut8_cfg_chain #(.BITS(CFG_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (cfg_en),
        .shift_din (cfg_din),
        .table_q   (table_q)
    );

    lut8_route u_route (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .pins  (lut_in),
        .route (route)
    );

    lut8_eval u_eval (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .route   (route),
        .table_q (table_q),
        .res     (res)
    );

    for (genvar k = 0; k < N_OUT; k++) begin : g_out
        lut8_out_bit u_out (
            .clk     (clk),
            .rst     (rst),
            .ce      (ce),
            .hold    (cfg_en),
            .use_reg (reg_sel[k]),
            .d       (res[k]),
            .y       (y[k])
        );
    end

    // R9: combinational select passes the result through unchanged
    a_r9_comb_path: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == '0) |-> (y == res));

endmodule

// File: tb/sim_lut8_frac_cell.sv
`timescale 1ns/1ps
module sim_lut8_frac_cell;

    logic       clk = 1'b1;
    logic       rst = 1'b1;
    logic [2:0] mode = '0;
    logic [7:0] lut_in = '0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       ce = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [1:0] y;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [1:0] q_exp[$];
    string      q_req[$];
    bit         q_chk[$];

    logic [127:0] m_tbl = '0;
    logic [1:0]   m_q = '0;

    string mreq[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R7"};

    always #2.5 clk = ~clk;

    lut8_frac_cell u0 (
        .clk(clk), .rst(rst), .mode(mode), .lut_in(lut_in),
        .cfg_en(cfg_en), .cfg_din(cfg_din), .ce(ce),
        .reg_sel(reg_sel), .y(y)
    );

    function automatic logic [1:0] f_model(input logic [2:0] md,
                                           input logic [7:0] x,
                                           input logic [127:0] t);
        logic [63:0] ta;
        logic [63:0] tb;
        ta = t[63:0];
        tb = t[127:64];
        case (md)
            3'd0: return {tb[x[7:4]], ta[x[3:0]]};
            3'd1: return {tb[x[7:5]], ta[x[4:0]]};
            3'd2: return {tb[x[7:4]], ta[x[4:0]]};
            3'd3: return {tb[x[7:3]], ta[x[4:0]]};
            3'd4: return {1'b0, ta[x[5:0]]};
            3'd5: return {ta[{x[7:6], x[3:0]}], ta[x[5:0]]};
            default: return 2'b00;
        endcase
    endfunction

    task automatic cyc(input logic r, input logic [2:0] md, input logic [7:0] x,
                       input logic c, input logic cen, input logic din,
                       input logic [1:0] sel, input bit chk, input string req);
        logic [1:0] comb_old;
        logic [1:0] comb_new;
        logic [1:0] e;
        @(negedge clk);
        rst = r; mode = md; lut_in = x; ce = c;
        cfg_en = cen; cfg_din = din; reg_sel = sel;
        comb_old = f_model(md, x, m_tbl);
        if (r) begin
            m_q = '0;
            m_tbl = '0;
        end else begin
            if (c && !cen) m_q = comb_old;
            if (cen) m_tbl = {m_tbl[126:0], din};
        end
        comb_new = f_model(md, x, m_tbl);
        for (int k = 0; k < 2; k++) e[k] = sel[k] ? m_q[k] : comb_new[k];
        q_exp.push_back(e);
        q_req.push_back(req);
        q_chk.push_back(chk);
    endtask

    task automatic load(input logic [127:0] img, input logic [1:0] sel,
                        input bit chk, input string req);
        for (int i = 0; i < 128; i++)
            cyc(1'b0, 3'd3, 8'($urandom), 1'b1, 1'b1, img[127-i], sel, chk, req);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [1:0] e;
                string r;
                bit c;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                c = q_chk.pop_front();
                if (c) begin
                    checks++;
                    if (y !== e) begin
                        errors++;
                        $display("FAIL %s: y=%b expected %b (mode=%0d in=%h sel=%b)",
                                 r, y, e, mode, lut_in, reg_sel);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        logic [127:0] xbar;
        // R12: reset state of the registers
        cyc(1'b1, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, "R12");
        cyc(1'b1, 3'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, "R12");
        cyc(1'b0, 3'd0, 8'h5A, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R12");

        // R8: load a known image, probe the end bits
        load({64'hA5C3_0F96_3C5A_F00F, 64'h6E2B_91D4_07F8_C3A1}, 2'b00, 1'b0, "R8");
        cyc(1'b0, 3'd4, 8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R8");
        cyc(1'b0, 3'd4, 8'h3F, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R8");
        cyc(1'b0, 3'd3, 8'hFF, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R8");

        // R1..R7: every mode code under many pin patterns
        for (int md = 0; md < 8; md++)
            for (int n = 0; n < 40; n++)
                cyc(1'b0, 3'(md), 8'($urandom), 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, mreq[md]);

        // R10: registers capture with enable
        for (int n = 0; n < 20; n++)
            cyc(1'b0, 3'd3, 8'($urandom), 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, "R10");
        // R9: mixed selects
        for (int n = 0; n < 20; n++)
            cyc(1'b0, 3'd0, 8'($urandom), 1'b1, 1'b0, 1'b0, 2'(n), 1'b1, "R9");
        // R10: enable low holds
        for (int n = 0; n < 20; n++)
            cyc(1'b0, 3'd2, 8'($urandom), 1'b0, 1'b0, 1'b0, 2'b11, 1'b1, "R10");

        // R11: reload with ce high, registered outputs must not move
        cyc(1'b0, 3'd0, 8'h0F, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, "R10");
        load({64'h1357_9BDF_0246_8ACE, 64'hFEDC_BA98_7654_3210}, 2'b11, 1'b1, "R11");
        for (int n = 0; n < 30; n++)
            cyc(1'b0, 3'(n % 6), 8'($urandom), 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R8");

        // R6: crossbar table in the twin mode
        for (int i = 0; i < 64; i++) begin
            logic [5:0] ii;
            ii = 6'(i);
            xbar[i] = ii[ii[5:4]];
            xbar[64+i] = ~ii[0];
        end
        load(xbar, 2'b00, 1'b0, "R6");
        for (int n = 0; n < 30; n++)
            cyc(1'b0, 3'd5, 8'($urandom), 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R6");

        // R12: mid-run reset clears registers and table
        cyc(1'b0, 3'd4, 8'h3F, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, "R12");
        cyc(1'b1, 3'd0, 8'h00, 1'b1, 1'b0, 1'b0, 2'b11, 1'b1, "R12");
        for (int n = 0; n < 8; n++)
            cyc(1'b0, 3'd0, 8'($urandom), 1'b0, 1'b0, 1'b0, 2'b00, 1'b1, "R12");

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule